// File: doc/BRIEF.md
# Private Interrupt Pending/Active State Bank

This block keeps the pending and active state for a bank of private interrupts: by default 16 software-generated ones on bits [15:0] and 16 peripheral ones on bits [31:16]. Each interrupt takes a hardware line, with a per-interrupt choice of edge or level triggering. It also takes strobes for software set-pending, acknowledge (pending to active) and deactivate. Software reads the pending state, and removes it with a write-one-to-clear register, through a small register bus that carries an address, write data and a secure/non-secure attribute.

Register accesses are masked in three ways. A routing-enable flag opens or closes the whole register. A per-interrupt group mask marks each interrupt as non-secure (1) or secure (0). A global security-disable flag controls whether non-secure accesses may see and clear the secure interrupts. Level-triggered interrupts whose line is still high cannot be cleared by software. Pending state that software latched with a set-pending strobe can always be cleared.

Top module: `ipb_bank`

## Requirements
- R1: After reset every interrupt is inactive (pend_o and act_o all zero) and bus_rdata is zero.
- R2: An edge-triggered interrupt becomes pending one cycle after a rising edge on its line or a sw_set strobe, and stays pending while the line is held high. A read of the clear register returns interrupt x on data bit x.
- R3: A write of 1 to bit x of the clear register moves interrupt x from pending to inactive, or from active-and-pending to active, leaving the active bit unchanged. Writing 0 to a bit changes nothing.
- R4: cpu_ack on a pending interrupt sets it active and removes the latched pending state one cycle later. cpu_ack on a non-pending interrupt has no effect. cpu_deact clears the active bit.
- R5: A level-triggered interrupt (irq_is_edge=0) is pending in the same cycle its line is high, and a clear write does not remove it while the line stays high.
- R6: A sw_set strobe on a level-triggered interrupt holds it pending after its line falls, until a clear write or an acknowledge removes it.
- R7: With route_en=0 every bit reads as zero and writes are ignored.
- R8: With sec_off=0, a non-secure access (bus_ns=1) reads zero from, and cannot clear, interrupts whose irq_grp_ns bit is 0. Secure accesses, or any access with sec_off=1, reach all bits.
- R9: Only address CLR_OFS (default 0x280) responds. Reads of other addresses return zero and writes to them are ignored. Read data appears one cycle after the read and is held until the next read.
- R10: A sw_set strobe in the same cycle as a clear write leaves the interrupt pending. cpu_ack in the same cycle as cpu_deact leaves the interrupt active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | N_SGI+N_PPI | Hardware interrupt lines |
| irq_is_edge | input | N_SGI+N_PPI | 1 = edge-triggered, 0 = level-triggered |
| irq_grp_ns | input | N_SGI+N_PPI | 1 = non-secure group, 0 = secure group |
| sw_set | input | N_SGI+N_PPI | Software set-pending strobes |
| cpu_ack | input | N_SGI+N_PPI | Acknowledge strobes (pending to active) |
| cpu_deact | input | N_SGI+N_PPI | Deactivate strobes |
| route_en | input | 1 | Register access enable |
| sec_off | input | 1 | Security-disable flag |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the frame |
| bus_wdata | input | 32 | Write data |
| bus_ns | input | 1 | 1 = non-secure access |
| bus_rdata | output | 32 | Registered read data |
| pend_o | output | N_SGI+N_PPI | Pending state per interrupt |
| act_o | output | N_SGI+N_PPI | Active state per interrupt |

## Verification
The bench builds the bank with its defaults: 16 + 16 interrupts, which exactly fill the 32-bit word, a 12-bit address and the clear register at 0x280. With this build, every data bit maps to an interrupt, so mask patterns that split the software-generated half from the peripheral half can test the security masking. An address 4 bytes above the register exercises the decode of unmapped offsets. The narrower builds, in which the upper data bits read as padding, are covered only by the elaboration checks.

// File: rtl/ipb_pkg.sv
`timescale 1ns/1ps
package ipb_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      IRQ_IDLE     = 2'b00,
      IRQ_PEND     = 2'b01,
      IRQ_ACT      = 2'b10,
      IRQ_ACT_PEND = 2'b11
   } irq_state_e;

   typedef struct packed {
      logic line;
      logic is_edge;
      logic sw_set;
      logic clr;
      logic ack;
      logic deact;
   } cell_ctl_t;
endpackage

// File: rtl/ipb_cell.sv
`timescale 1ns/1ps
module ipb_cell
   import ipb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cell_ctl_t  ctl,
   output irq_state_e state
);
   logic line_q, sw_q, edge_q, act_q;
   logic rise, pend, take;

   always_comb begin
      rise = ctl.line & ~line_q;
      pend = ctl.is_edge ? edge_q : (ctl.line | sw_q);
      take = ctl.ack & pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         sw_q   <= 1'b0;
         edge_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         line_q <= ctl.line;
         // edge latch: new events win over removal in the same cycle
         if (!ctl.is_edge)              edge_q <= 1'b0;
         else if (rise || ctl.sw_set)   edge_q <= 1'b1;
         else if (ctl.clr || take)      edge_q <= 1'b0;
         // software latch for level mode
         if (ctl.is_edge)               sw_q <= 1'b0;
         else if (ctl.sw_set)           sw_q <= 1'b1;
         else if (ctl.clr || take)      sw_q <= 1'b0;
         // active: acknowledge wins over deactivate
         if (take)                      act_q <= 1'b1;
         else if (ctl.deact)            act_q <= 1'b0;
      end
   end

   assign state = irq_state_e'({act_q, pend});
endmodule

// File: rtl/ipb_access_mask.sv
`timescale 1ns/1ps
module ipb_access_mask #(
   parameter int unsigned N = 32
) (
   input  logic         route_en,
   input  logic         sec_off,
   input  logic         bus_ns,
   input  logic [N-1:0] grp_ns,
   output logic [N-1:0] mask
);
   always_comb begin
      if (!route_en)               mask = '0;
      else if (sec_off || !bus_ns) mask = '1;
      else                         mask = grp_ns;
   end
endmodule

// File: rtl/ipb_regport.sv
`timescale 1ns/1ps
module ipb_regport #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N       = 32,
   parameter int unsigned CLR_OFS = 32'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N-1:0]      mask,
   input  logic [N-1:0]      pend,
   output logic [N-1:0]      clr,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CLR_OFS);

   logic              hit;
   logic [DATA_W-1:0] rd_word;
   logic [N-1:0]      vis;

   assign hit = sel && (addr == HIT_ADDR);
   assign vis = pend & mask;
   assign clr = (hit && wr) ? (wdata[N-1:0] & mask) : '0;

   generate
      if (N == DATA_W) begin : g_full
         assign rd_word = vis;
      end else begin : g_pad
         assign rd_word = {{(DATA_W-N){1'b0}}, vis};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rdata <= '0;
      else if (sel && !wr)  rdata <= hit ? rd_word : '0;
   end
endmodule

// File: rtl/ipb_bank.sv
`timescale 1ns/1ps
module ipb_bank
   import ipb_pkg::*;
#(
   parameter int unsigned N_SGI   = 16,
   parameter int unsigned N_PPI   = 16,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned CLR_OFS = 32'h280
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SGI+N_PPI-1:0] irq_line,
   input  logic [N_SGI+N_PPI-1:0] irq_is_edge,
   input  logic [N_SGI+N_PPI-1:0] irq_grp_ns,
   input  logic [N_SGI+N_PPI-1:0] sw_set,
   input  logic [N_SGI+N_PPI-1:0] cpu_ack,
   input  logic [N_SGI+N_PPI-1:0] cpu_deact,
   input  logic                   route_en,
   input  logic                   sec_off,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   input  logic                   bus_ns,
   output logic [31:0]            bus_rdata,
   output logic [N_SGI+N_PPI-1:0] pend_o,
   output logic [N_SGI+N_PPI-1:0] act_o
);
   localparam int unsigned N_IRQ  = N_SGI + N_PPI;
   localparam int unsigned DATA_W = WORD_W;

   generate
      if (N_IRQ > DATA_W) begin : g_err_width
         $error("ipb_bank: interrupt count exceeds register width");
      end
      if (N_IRQ == 0) begin : g_err_empty
         $error("ipb_bank: no interrupts configured");
      end
      if ((CLR_OFS % 4) != 0) begin : g_err_align
         $error("ipb_bank: register offset not word aligned");
      end
      if ((CLR_OFS >> ADDR_W) != 0) begin : g_err_range
         $error("ipb_bank: register offset outside address range");
      end
   endgenerate

   logic [N_IRQ-1:0] mask;
   logic [N_IRQ-1:0] clr_vec;

   ipb_access_mask #(.N(N_IRQ)) u_mask (
      .route_en (route_en),
      .sec_off  (sec_off),
      .bus_ns   (bus_ns),
      .grp_ns   (irq_grp_ns),
      .mask     (mask)
   );

   ipb_regport #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .N       (N_IRQ),
      .CLR_OFS (CLR_OFS)
   ) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bus_sel),
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .mask  (mask),
      .pend  (pend_o),
      .clr   (clr_vec),
      .rdata (bus_rdata)
   );

   generate
      for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
         cell_ctl_t  c;
         irq_state_e st;
         assign c = '{line:    irq_line[i],
                      is_edge: irq_is_edge[i],
                      sw_set:  sw_set[i],
                      clr:     clr_vec[i],
                      ack:     cpu_ack[i],
                      deact:   cpu_deact[i]};
         ipb_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (c),
            .state (st)
         );
         assign pend_o[i] = (st == IRQ_PEND) || (st == IRQ_ACT_PEND);
         assign act_o[i]  = (st == IRQ_ACT)  || (st == IRQ_ACT_PEND);
      end
   endgenerate
endmodule

// File: rtl/ipb_bank_chk.sv
`timescale 1ns/1ps
module ipb_bank_chk #(
   parameter int unsigned N_IRQ   = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned CLR_OFS = 32'h280
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_IRQ-1:0]  irq_is_edge,
   input logic [N_IRQ-1:0]  irq_grp_ns,
   input logic [N_IRQ-1:0]  cpu_ack,
   input logic              route_en,
   input logic              sec_off,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ns,
   input logic [31:0]       bus_rdata,
   input logic [N_IRQ-1:0]  pend_o,
   input logic [N_IRQ-1:0]  act_o
);
   logic past_ok;
   logic rd_acc, wr_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign rd_acc = bus_sel && !bus_wr;
   assign wr_acc = bus_sel && bus_wr && (bus_addr == ADDR_W'(CLR_OFS));

   AST_NOROUTE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(rd_acc && !route_en) |-> bus_rdata == '0); // R7

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(rd_acc) |-> $stable(bus_rdata)); // R9

   generate
      for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
         AST_ACT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $rose(act_o[i]) |-> $past(cpu_ack[i] && pend_o[i])); // R4

         AST_EDGE_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $fell(pend_o[i]) && irq_is_edge[i] && $past(irq_is_edge[i])
            |-> $past(cpu_ack[i] || (wr_acc && bus_wdata[i]))); // R3

         AST_NS_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(rd_acc && bus_ns && !sec_off && !irq_grp_ns[i])
            |-> !bus_rdata[i]); // R8
      end
   endgenerate
endmodule

bind ipb_bank ipb_bank_chk #(
   .N_IRQ   (N_SGI + N_PPI),
   .ADDR_W  (ADDR_W),
   .CLR_OFS (CLR_OFS)
) u_chk (.*);

// File: tb/tb_ipb_bank.sv
`timescale 1ns/1ps
module tb_ipb_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_line = '0, irq_is_edge = '1, irq_grp_ns = 32'h0000_FFFF;
   logic [31:0] sw_set = '0, cpu_ack = '0, cpu_deact = '0;
   logic        route_en = 1'b1, sec_off = 1'b1;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_ns = 1'b0;
   logic [11:0] bus_addr = 12'h280;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, pend_o, act_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ipb_bank dut (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_is_edge(irq_is_edge),
      .irq_grp_ns(irq_grp_ns), .sw_set(sw_set), .cpu_ack(cpu_ack),
      .cpu_deact(cpu_deact), .route_en(route_en), .sec_off(sec_off),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ns(bus_ns), .bus_rdata(bus_rdata),
      .pend_o(pend_o), .act_o(act_o)
   );

   // {set mask, write data, wr_ns, wr_sec_off, rd_ns, rd_sec_off, expected read}
   localparam logic [99:0] VECS [6] = '{
      {32'hF0F0_00FF, 32'h0000_0000, 4'b0101, 32'hF0F0_00FF},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1000, 32'hFFFF_0000},
      {32'hFFFF_FFFF, 32'h0000_0F0F, 4'b0000, 32'hFFFF_F0F0},
      {32'h1234_5678, 32'h0000_FFFF, 4'b1111, 32'h1234_0000},
      {32'h8000_0001, 32'h0000_0000, 4'b1010, 32'h0000_0001},
      {32'hAAAA_5555, 32'hFFFF_0000, 4'b0101, 32'h0000_5555}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input logic ns);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_ns = ns;
      step();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_reg(input logic [11:0] a, input logic ns, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_ns = ns;
      step();
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_set(input logic [31:0] m);
      sw_set = m;
      step();
      sw_set = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [99:0] e;
      logic [31:0] d;
      repeat (3) step();
      chk("R1 pending in reset", pend_o, 32'h0);
      rst_n = 1'b1;
      step();
      chk("R1 pending after reset", pend_o, 32'h0);
      chk("R1 active after reset", act_o, 32'h0);
      chk("R1 rdata after reset", bus_rdata, 32'h0);

      // table walk: masking by security state, write-0 and write-1 behaviour (R3, R8)
      for (int v = 0; v < 6; v++) begin
         e = VECS[v];
         sec_off = 1'b1;
         wr_reg(12'h280, 32'hFFFF_FFFF, 1'b0);
         pulse_set(e[99:68]);
         sec_off = e[34];
         wr_reg(12'h280, e[67:36], e[35]);
         sec_off = e[32];
         rd_reg(12'h280, e[33], d);
         chk($sformatf("R3/R8 vector %0d", v), d, e[31:0]);
      end
      sec_off = 1'b1;
      wr_reg(12'h280, 32'hFFFF_FFFF, 1'b0);
      chk("R3 all cleared", pend_o, 32'h0);

      // acknowledge / deactivate on bit 20 (R2, R3, R4)
      pulse_set(32'h0010_0000);
      chk("R2 set-pending", pend_o, 32'h0010_0000);
      cpu_ack[20] = 1'b1; step(); cpu_ack = '0;
      chk("R4 ack active", act_o, 32'h0010_0000);
      chk("R4 ack clears pending", pend_o, 32'h0);
      pulse_set(32'h0010_0000);
      chk("R4 active-and-pending pend", pend_o, 32'h0010_0000);
      rd_reg(12'h280, 1'b0, d);
      chk("R2 read bit position", d, 32'h0010_0000);
      wr_reg(12'h280, 32'h0010_0000, 1'b0);
      chk("R3 clear leaves pend 0", pend_o, 32'h0);
      chk("R3 clear keeps active", act_o, 32'h0010_0000);
      cpu_deact[20] = 1'b1; step(); cpu_deact = '0;
      chk("R4 deactivate", act_o, 32'h0);
      cpu_ack[21] = 1'b1; step(); cpu_ack = '0;
      chk("R4 ack without pending", act_o, 32'h0);

      // edge on a held line (R2)
      irq_line[17] = 1'b1; step();
      chk("R2 rising edge pends", pend_o, 32'h0002_0000);
      wr_reg(12'h280, 32'h0002_0000, 1'b0);
      step();
      chk("R2 held line no re-pend", pend_o, 32'h0);
      irq_line[17] = 1'b0; step();

      // level-sensitive bit 5 (R5)
      irq_is_edge[5] = 1'b0; irq_line[5] = 1'b1; step();
      chk("R5 level pending", pend_o, 32'h0000_0020);
      wr_reg(12'h280, 32'h0000_0020, 1'b0);
      chk("R5 clear ignored while high", pend_o, 32'h0000_0020);
      irq_line[5] = 1'b0; step();
      chk("R5 line low not pending", pend_o, 32'h0);

      // software latch on level bit 6 (R6)
      irq_is_edge[6] = 1'b0;
      pulse_set(32'h0000_0040);
      chk("R6 sw latch pends", pend_o, 32'h0000_0040);
      irq_line[6] = 1'b1; step(); irq_line[6] = 1'b0; step();
      chk("R6 latch kept after line falls", pend_o, 32'h0000_0040);
      wr_reg(12'h280, 32'h0000_0040, 1'b0);
      chk("R6 clear removes latch", pend_o, 32'h0);
      irq_line[6] = 1'b1;
      pulse_set(32'h0000_0040);
      wr_reg(12'h280, 32'h0000_0040, 1'b0);
      chk("R6 line high keeps pending", pend_o, 32'h0000_0040);
      irq_line[6] = 1'b0; step();
      chk("R6 latch gone after clear", pend_o, 32'h0);
      irq_is_edge = '1; step();

      // routing disabled (R7)
      pulse_set(32'h0000_0003);
      route_en = 1'b0;
      rd_reg(12'h280, 1'b0, d);
      chk("R7 read zero", d, 32'h0);
      wr_reg(12'h280, 32'hFFFF_FFFF, 1'b0);
      route_en = 1'b1;
      rd_reg(12'h280, 1'b0, d);
      chk("R7 write ignored", d, 32'h0000_0003);

      // address decode and hold (R9)
      rd_reg(12'h284, 1'b0, d);
      chk("R9 other offset reads zero", d, 32'h0);
      wr_reg(12'h284, 32'hFFFF_FFFF, 1'b0);
      rd_reg(12'h280, 1'b0, d);
      chk("R9 other offset write ignored", d, 32'h0000_0003);
      wr_reg(12'h280, 32'h0000_0003, 1'b0);
      step(); step();
      chk("R9 rdata held", bus_rdata, 32'h0000_0003);
      chk("R9 cleared state", pend_o, 32'h0);

      // same-cycle priorities (R10)
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h8; bus_ns = 1'b0;
      sw_set = 32'h8;
      step();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; sw_set = '0;
      chk("R10 set beats clear", pend_o, 32'h0000_0008);
      pulse_set(32'h0000_0010);
      cpu_ack[4] = 1'b1; cpu_deact[4] = 1'b1; step();
      cpu_ack = '0; cpu_deact = '0;
      chk("R10 ack beats deactivate", act_o, 32'h0000_0010);

      finish_run();
   end
endmodule